// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether a single memory access may proceed under a table of protection entries. Each request carries a byte address, a byte count, the requested read/write/execute privileges and a flag saying whether the requester runs in machine mode. The block receives, from separate storage and decode logic, the inclusive lower and upper byte bound of every entry together with the entry's configuration byte. It also receives two security-policy bits: a lockdown bit that switches to a stricter permission table, and a whitelist bit that denies all unmatched accesses.

The entries are scanned in index order. The first active entry that contains either end of the access decides the result. When only one end lies inside that entry the access is refused outright. When both ends lie inside, the allowed mask comes from the entry's permission bits or, under lockdown, from a fixed 16-row table. When no entry is touched, a default policy applies that depends on the two security bits and the mode. The result is registered: one cycle after a request the block presents the allowed R/W/X mask and a grant flag.

Privilege encodings, used on every mask port and in the low bits of the configuration byte: bit 0 = read, bit 1 = write, bit 2 = execute. Configuration byte: bits [2:0] permissions, bits [4:3] address-match mode (zero means the entry is off, any other value means it is active), bit 7 lock, bits [6:5] unused.

Top module: `pmp_chk`

## Requirements
- R1: Among active entries that contain at least one end of the access, the lowest-indexed one decides the result, even when a higher entry would give a different mask.
- R2: If the deciding entry contains exactly one of the two ends (first byte, last byte), the allowed mask is 0 and grant is 0, even if a higher entry holds the whole access.
- R3: The last byte is addr+size-1 when size is nonzero. A size of 0 means the last byte is the end of the 4 KiB page holding addr when paging_en is 1, and addr+3 (four bytes) when paging_en is 0.
- R4: With lockdown clear, a fully containing entry gives RWX (7) to machine mode if its lock bit (bit 7) is 0, and otherwise gives its configuration bits [2:0]. For lower modes it always gives bits [2:0].
- R5: With lockdown set and machine mode, the index {lock,R,W,X} of the deciding entry maps as: 2, 3, 14 to RW (3); 9, 10 to X (4); 11, 13 to RX (5); 12, 15 to R (1); every other index to 0.
- R6: With lockdown set and lower mode, the index maps as: 1, 10, 11 to X (4); 2, 4, 15 to R (1); 3, 6 to RW (3); 5 to RX (5); 7 to RWX (7); every other index to 0.
- R7: With no deciding entry and the whitelist bit set, the allowed mask is 0 for every mode.
- R8: With no deciding entry, whitelist clear and lockdown set, a machine-mode request with execute (bit 2) clear gets RW (3). Any other request gets 0.
- R9: With no deciding entry and both security bits clear, machine mode gets RWX (7) and lower modes get 0.
- R10: Grant is 1 exactly when every requested privilege bit is present in the allowed mask.
- R11: Results appear on the cycle after req_valid. rsp_valid follows req_valid with one cycle of delay and is 0 after reset, with rsp_allow and rsp_grant also 0.
- R12: An entry whose mode field (bits [4:3]) is 0 is ignored, even if it partially or fully covers the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | First byte address of the access |
| req_size | input | AW | Byte count, 0 for implicit size |
| req_priv | input | 3 | Requested privileges {X,W,R} |
| req_mmode | input | 1 | 1 = machine mode, 0 = lower mode |
| paging_en | input | 1 | Address translation active (selects implicit size) |
| sec_mml | input | 1 | Lockdown policy bit |
| sec_mmwp | input | 1 | Whitelist policy bit |
| ent_lo | input | N*AW | Inclusive lower byte bound per entry, entry i at [i*AW +: AW] |
| ent_hi | input | N*AW | Inclusive upper byte bound per entry |
| ent_cfg | input | N*8 | Configuration byte per entry |
| rsp_valid | output | 1 | Result valid |
| rsp_allow | output | 3 | Allowed privileges {X,W,R} |
| rsp_grant | output | 1 | All requested privileges allowed |

## Verification
The entry table is set up with nested and overlapping regions, so that the same address range is claimed by a narrow read-only entry, a wide full-access entry and an inactive entry. Accesses placed fully inside, straddling the narrow entry's upper edge, and sized implicitly with and without paging show the difference between first-match priority, partial-overlap refusal and the size rule. A sweep of all sixteen lock/permission combinations in both modes under lockdown covers each row of both tables. Unmatched addresses under each combination of the security bits cover the three default policies. Each request also carries read, write or execute requests, so that grant is compared against the allowed mask.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef logic [2:0] perm_t;

  localparam perm_t PERM_NONE = 3'b000;
  localparam perm_t PERM_R    = 3'b001;
  localparam perm_t PERM_RW   = 3'b011;
  localparam perm_t PERM_X    = 3'b100;
  localparam perm_t PERM_RX   = 3'b101;
  localparam perm_t PERM_RWX  = 3'b111;

  localparam int CFG_LOCK_BIT = 7;
  localparam int CFG_MODE_LO  = 3;
  localparam int CFG_MODE_HI  = 4;

  // lockdown table, machine mode; index is {lock, r, w, x}
  function automatic perm_t lockdown_mach(input logic [3:0] idx);
    case (idx)
      4'd2, 4'd3, 4'd14: lockdown_mach = PERM_RW;
      4'd9, 4'd10:       lockdown_mach = PERM_X;
      4'd11, 4'd13:      lockdown_mach = PERM_RX;
      4'd12, 4'd15:      lockdown_mach = PERM_R;
      default:           lockdown_mach = PERM_NONE;
    endcase
  endfunction

  // lockdown table, lower modes
  function automatic perm_t lockdown_lower(input logic [3:0] idx);
    case (idx)
      4'd1, 4'd10, 4'd11: lockdown_lower = PERM_X;
      4'd2, 4'd4, 4'd15:  lockdown_lower = PERM_R;
      4'd3, 4'd6:         lockdown_lower = PERM_RW;
      4'd5:               lockdown_lower = PERM_RX;
      4'd7:               lockdown_lower = PERM_RWX;
      default:            lockdown_lower = PERM_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pmp_range_cmp.sv
module pmp_range_cmp #(
  parameter int AW = 32
) (
  input  logic          active,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic          full,
  output logic          part
);
  logic in_first;
  logic in_last;

  always_comb begin
    in_first = (first >= lo) && (first <= hi);
    in_last  = (last  >= lo) && (last  <= hi);
    full     = active && in_first && in_last;
    part     = active && (in_first ^ in_last);
  end
endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel #(
  parameter int N = 16
) (
  input  logic [N-1:0] full,
  input  logic [N-1:0] part,
  output logic [N-1:0] sel,
  output logic         any_hit,
  output logic         partial
);
  logic found;

  always_comb begin
    sel     = '0;
    found   = 1'b0;
    partial = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && (full[i] || part[i])) begin
        found   = 1'b1;
        sel[i]  = 1'b1;
        partial = part[i];
      end
    end
    any_hit = found;
  end

  always_comb begin
    AST_ONE_WINNER: assert ($onehot0(sel)); // R1
  end
endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
  import pmp_chk_pkg::*;
(
  input  logic       hit,
  input  logic       partial,
  input  logic [7:0] cfg,
  input  logic       mmode,
  input  logic       mml,
  input  logic       mmwp,
  input  perm_t      req,
  output perm_t      allow,
  output logic       grant
);
  logic [3:0] tbl_idx;
  logic       lock;
  logic       unused_cfg;

  assign lock       = cfg[CFG_LOCK_BIT];
  assign tbl_idx    = {lock, cfg[0], cfg[1], cfg[2]};
  assign unused_cfg = ^{cfg[6:3]};

  always_comb begin
    if (hit && partial) begin
      allow = PERM_NONE;
    end else if (hit) begin
      if (!mml)
        allow = (mmode && !lock) ? PERM_RWX : perm_t'(cfg[2:0]);
      else if (mmode)
        allow = lockdown_mach(tbl_idx);
      else
        allow = lockdown_lower(tbl_idx);
    end else if (mmwp) begin
      allow = PERM_NONE;
    end else if (mml) begin
      allow = (mmode && !req[2]) ? PERM_RW : PERM_NONE;
    end else begin
      allow = mmode ? PERM_RWX : PERM_NONE;
    end
    grant = ((req & ~allow) == 3'b000) && !(hit && partial);
  end
endmodule

// File: rtl/pmp_chk.sv
module pmp_chk
  import pmp_chk_pkg::*;
#(
  parameter int N         = 16,
  parameter int AW        = 32,
  parameter int XLEN      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [AW-1:0]   req_size,
  input  logic [2:0]      req_priv,
  input  logic            req_mmode,
  input  logic            paging_en,
  input  logic            sec_mml,
  input  logic            sec_mmwp,
  input  logic [N*AW-1:0] ent_lo,
  input  logic [N*AW-1:0] ent_hi,
  input  logic [N*8-1:0]  ent_cfg,
  output logic            rsp_valid,
  output logic [2:0]      rsp_allow,
  output logic            rsp_grant
);
  localparam logic [AW-1:0] WORD_TAIL = AW'(XLEN / 8 - 1);
  localparam logic [AW-1:0] PAGE_MASK = {{(AW-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  logic [AW-1:0] last_byte;
  logic [N-1:0]  full_v;
  logic [N-1:0]  part_v;
  logic [N-1:0]  sel_v;
  logic          any_hit;
  logic          partial;
  logic [7:0]    win_cfg;
  perm_t         allow_c;
  logic          grant_c;
  perm_t         q_req;
  logic          q_part;

  always_comb begin
    if (req_size != '0)
      last_byte = req_addr + req_size - AW'(1);
    else if (paging_en)
      last_byte = req_addr | PAGE_MASK;
    else
      last_byte = req_addr + WORD_TAIL;
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    pmp_range_cmp #(.AW(AW)) u_cmp (
      .active (ent_cfg[g*8+CFG_MODE_HI -: 2] != 2'b00),
      .lo     (ent_lo[g*AW +: AW]),
      .hi     (ent_hi[g*AW +: AW]),
      .first  (req_addr),
      .last   (last_byte),
      .full   (full_v[g]),
      .part   (part_v[g])
    );
  end

  pmp_prio_sel #(.N(N)) u_sel (
    .full    (full_v),
    .part    (part_v),
    .sel     (sel_v),
    .any_hit (any_hit),
    .partial (partial)
  );

  always_comb begin
    win_cfg = '0;
    for (int i = 0; i < N; i++)
      win_cfg = win_cfg | (ent_cfg[i*8 +: 8] & {8{sel_v[i]}});
  end

  pmp_perm_eval u_eval (
    .hit     (any_hit),
    .partial (partial),
    .cfg     (win_cfg),
    .mmode   (req_mmode),
    .mml     (sec_mml),
    .mmwp    (sec_mmwp),
    .req     (req_priv),
    .allow   (allow_c),
    .grant   (grant_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= '0;
      rsp_grant <= 1'b0;
      q_req     <= '0;
      q_part    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_allow <= allow_c;
        rsp_grant <= grant_c;
        q_req     <= req_priv;
        q_part    <= any_hit && partial;
      end
    end
  end

  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_grant) |-> ((q_req & ~rsp_allow) == 3'b000)); // R10
  AST_PARTIAL_DENY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && q_part) |-> (rsp_allow == 3'b000 && !rsp_grant)); // R2
  AST_WHITELIST_DENY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !any_hit && sec_mmwp) |=> (rsp_allow == 3'b000)); // R7
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R11
  AST_IDLE_DELAY: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R11
endmodule

// File: tb/tb_pmp_chk.sv
module tb_pmp_chk;
  localparam int N  = 16;
  localparam int AW = 32;

  typedef struct {
    logic [2:0] allow;
    logic       grant;
    string      tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [AW-1:0]   req_size = '0;
  logic [2:0]      req_priv = '0;
  logic            req_mmode = 1'b0;
  logic            paging_en = 1'b0;
  logic            sec_mml = 1'b0;
  logic            sec_mmwp = 1'b0;
  logic [N*AW-1:0] ent_lo;
  logic [N*AW-1:0] ent_hi;
  logic [N*8-1:0]  ent_cfg;
  logic            rsp_valid;
  logic [2:0]      rsp_allow;
  logic            rsp_grant;

  logic [AW-1:0] lo_a [N];
  logic [AW-1:0] hi_a [N];
  logic [7:0]    cfg_a [N];
  logic [2:0]    tbl_m [16];
  logic [2:0]    tbl_u [16];

  exp_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_lo[i*AW +: AW] = lo_a[i];
      ent_hi[i*AW +: AW] = hi_a[i];
      ent_cfg[i*8 +: 8]  = cfg_a[i];
    end
  end

  pmp_chk dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_priv(req_priv), .req_mmode(req_mmode),
    .paging_en(paging_en), .sec_mml(sec_mml), .sec_mmwp(sec_mmwp),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_grant(rsp_grant)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference from the requirements
  function automatic logic [2:0] ref_allow(input logic [AW-1:0] a, input logic [AW-1:0] sz,
                                           input logic [2:0] rq, input logic mm, output logic part);
    logic [AW-1:0] e;
    part = 1'b0;
    if (sz != 0) e = a + sz - 1;
    else if (paging_en) e = {a[AW-1:12], 12'hFFF};
    else e = a + 3;
    for (int i = 0; i < N; i++) begin
      logic s_in, e_in;
      if (cfg_a[i][4:3] == 2'b00) continue;
      s_in = (a >= lo_a[i]) && (a <= hi_a[i]);
      e_in = (e >= lo_a[i]) && (e <= hi_a[i]);
      if (s_in != e_in) begin part = 1'b1; return 3'b000; end
      if (s_in) begin
        if (!sec_mml) return (mm && !cfg_a[i][7]) ? 3'b111 : cfg_a[i][2:0];
        return mm ? tbl_m[{cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]}]
                  : tbl_u[{cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]}];
      end
    end
    if (sec_mmwp) return 3'b000;
    if (sec_mml) return (mm && !rq[2]) ? 3'b011 : 3'b000;
    return mm ? 3'b111 : 3'b000;
  endfunction

  task automatic drive(input string tag, input logic [AW-1:0] a, input logic [AW-1:0] sz,
                       input logic [2:0] rq, input logic mm);
    exp_t x;
    logic part;
    req_addr  = a;
    req_size  = sz;
    req_priv  = rq;
    req_mmode = mm;
    req_valid = 1'b1;
    x.allow = ref_allow(a, sz, rq, mm, part);
    x.grant = !part && ((rq & ~x.allow) == 3'b000);
    x.tag   = tag;
    sb.push_back(x);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        check("R11 unexpected response", 4'd1, 4'd0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        check({x.tag, " allow"}, {1'b0, rsp_allow}, {1'b0, x.allow});
        check({x.tag, " grant R10"}, {3'b0, rsp_grant}, {3'b0, x.grant});
      end
    end
  end

  initial begin
    tbl_m = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
    tbl_u = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};
    for (int i = 0; i < N; i++) begin
      lo_a[i] = 32'hFFFF_0000; hi_a[i] = 32'hFFFF_0000; cfg_a[i] = 8'h00;
    end
    lo_a[0] = 32'h11F0; hi_a[0] = 32'h1201; cfg_a[0] = 8'h07;  // inactive
    lo_a[1] = 32'h1000; hi_a[1] = 32'h10FF; cfg_a[1] = 8'h09;  // R
    lo_a[2] = 32'h1000; hi_a[2] = 32'h1FFF; cfg_a[2] = 8'h0F;  // RWX
    lo_a[3] = 32'h3000; hi_a[3] = 32'h3FFF; cfg_a[3] = 8'h89;  // locked R
    lo_a[5] = 32'h5000; hi_a[5] = 32'h5FFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset valid", {3'b0, rsp_valid}, 4'd0);
    check("R11 reset allow", {1'b0, rsp_allow}, 4'd0);
    check("R11 reset grant", {3'b0, rsp_grant}, 4'd0);

    drive("R1 first match write", 32'h1010, 4, 3'b010, 1'b0);
    drive("R1 first match read",  32'h1010, 4, 3'b001, 1'b0);
    drive("R2 straddle narrow",   32'h10FE, 4, 3'b001, 1'b0);
    drive("R12 inactive ignored", 32'h1200, 4, 3'b010, 1'b0);
    drive("R4 mach unlocked",     32'h1010, 4, 3'b010, 1'b1);
    drive("R4 mach locked",       32'h3000, 4, 3'b010, 1'b1);
    drive("R4 lower locked",      32'h3000, 4, 3'b001, 1'b0);
    drive("R3 implicit word in",  32'h10FC, 0, 3'b001, 1'b0);
    drive("R3 implicit word out", 32'h10FE, 0, 3'b001, 1'b0);
    paging_en = 1'b1;
    drive("R3 page tail",         32'h1F00, 0, 3'b100, 1'b0);
    drive("R3 page straddle",     32'h10F0, 0, 3'b001, 1'b0);
    paging_en = 1'b0;
    drive("R9 lower default",     32'h8000, 4, 3'b001, 1'b0);
    drive("R9 mach default",      32'h8000, 4, 3'b100, 1'b1);
    sec_mml = 1'b1;
    drive("R8 mach read",         32'h8000, 4, 3'b001, 1'b1);
    drive("R8 mach exec",         32'h8000, 4, 3'b100, 1'b1);
    drive("R8 lower read",        32'h8000, 4, 3'b001, 1'b0);
    for (int k = 0; k < 16; k++) begin
      cfg_a[5] = {k[3], 2'b00, 2'b01, k[0], k[1], k[2]};
      drive($sformatf("R5 row %0d", k), 32'h5100, 8, 3'b001, 1'b1);
      drive($sformatf("R6 row %0d", k), 32'h5100, 8, 3'b001, 1'b0);
    end
    sec_mmwp = 1'b1;
    drive("R7 mach whitelist",    32'h8000, 4, 3'b001, 1'b1);
    drive("R7 lower whitelist",   32'h8000, 4, 3'b000, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 queue drained", 4'(sb.size()), 4'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check("watchdog", 4'd1, 4'd0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule